// File: doc/BRIEF.md
# ISDN Channel Buffer Status Unit

This block is the double-buffered data path of one line port carrying two 32-bit bearer channels (B1, B2) and one 8-bit signalling channel (D). Each channel has a register facing the CPU and a shadow register facing the line. A single-cycle superframe strobe, arriving at 2 kHz, moves transmit data from the CPU registers to the line and received line data into the CPU registers. All three channels move together on that strobe.

Per channel the block tracks four flags: transmit empty, transmit underrun, receive full and receive overrun. A 16-bit status word collects them. The CPU reads the status word, reads the receive data and writes the transmit data over a small register bus. Reads are combinational: `cpu_rdata` is valid in the same cycle that `cpu_rd` is high. The side effects of a read take place at the clock edge that ends that cycle.

Top module: `isdn_chbuf`

## Requirements
- R1: After reset, every flag is clear except the three transmit-empty flags, which are set. The status word therefore reads 0x0032, and all data and shadow registers hold zero.
- R2: The status word sits in `cpu_rdata[15:0]`, with `cpu_rdata[31:12]` at zero. From bit 11 down to bit 0 it holds: B2 overrun, B1 overrun, B2 full, B1 full, B2 underrun, B1 underrun, B2 empty, B1 empty, D overrun, D underrun, D empty, D full.
- R3: On a superframe strobe, each transmit register is copied to its line output, which becomes visible in the next cycle, and each transmit-empty flag is set.
- R4: A superframe strobe that finds a transmit-empty flag already set also sets that channel's underrun flag, and the line output repeats the old data.
- R5: A CPU write to a transmit register loads it and clears that channel's empty flag. If the write lands in the same cycle as a superframe strobe, the line output takes the old contents and the empty flag ends up clear.
- R6: On a superframe strobe, each receive line input is captured into its receive register, which the CPU can read, and each receive-full flag is set.
- R7: A superframe strobe that finds a receive-full flag set sets that channel's overrun flag, and the new data overwrites the register. A CPU read of that register in the same cycle counts as taking the data, and no overrun is flagged.
- R8: A CPU read of a receive register returns its contents and clears that channel's full flag. If a superframe strobe falls in the same cycle, the full flag stays set.
- R9: A status read returns the current flags and clears all six error flags at the end of that cycle.
- R10: When a superframe strobe sets an error flag in the same cycle as a status read, the read returns the old value and the flag stays set.
- R11: An error flag never falls except at the end of a status read.
- R12: Register addresses are 0 for status, 1 for B1, 2 for B2 and 3 for D. `cpu_rdata` is zero whenever `cpu_rd` is low.
- R13: The D channel uses `cpu_wdata[7:0]` on writes and returns its 8 bits zero-extended on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Register select |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, combinational while `cpu_rd` is high |
| sf_tick | input | 1 | Superframe transfer strobe, one cycle |
| rx_b1_line | input | 32 | B1 receive shadow data |
| rx_b2_line | input | 32 | B2 receive shadow data |
| rx_d_line | input | 8 | D receive shadow data |
| tx_b1_line | output | 32 | B1 transmit shadow data |
| tx_b2_line | output | 32 | B2 transmit shadow data |
| tx_d_line | output | 8 | D transmit shadow data |

## Verification
The bench aims at cycles where a superframe strobe collides with a bus access. A design that let a status read win over the strobe would lose an underrun or overrun. A design that cleared the full flag on a read racing the strobe would hide freshly captured data. A design that flagged overrun for data the CPU was taking in that same cycle would report a false error. Repeated strobes with no CPU service check that stale transmit data goes out again and that received data is overwritten, with both error kinds raised. A long sweep mixes all four addresses, simultaneous read and write, and strobes against a model derived from the requirements. It also checks that the D channel masks write data to 8 bits and that error flags never drop without a status read.

// File: rtl/isdn_chbuf_pkg.sv
package isdn_chbuf_pkg;

    localparam int B_WIDTH = 32;
    localparam int D_WIDTH = 8;
    localparam int ADDR_W  = 2;
    localparam int STAT_W  = 16;
    localparam int N_CHAN  = 3;   // B1, B2, D
    localparam int N_BCH   = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STAT = 2'd0,
        SEL_B1   = 2'd1,
        SEL_B2   = 2'd2,
        SEL_D    = 2'd3
    } reg_sel_e;

    // Status word layout, bit 15 first.
    typedef struct packed {
        logic [3:0] rsvd;
        logic       b2_ovr;
        logic       b1_ovr;
        logic       b2_full;
        logic       b1_full;
        logic       b2_und;
        logic       b1_und;
        logic       b2_emp;
        logic       b1_emp;
        logic       d_ovr;
        logic       d_und;
        logic       d_emp;
        logic       d_full;
    } stat_t;

    localparam logic [STAT_W-1:0] STAT_RESET = 16'h0032;
    localparam logic [STAT_W-1:0] ERR_MASK   = 16'h0CCC;

    typedef struct packed {
        logic emp;
        logic und;
        logic full;
        logic ovr;
    } chan_flags_t;

    // Index 0 = B1, 1 = B2, 2 = D.
    function automatic stat_t build_stat(input chan_flags_t f [N_CHAN]);
        stat_t s;
        s.rsvd    = '0;
        s.b2_ovr  = f[1].ovr;
        s.b1_ovr  = f[0].ovr;
        s.b2_full = f[1].full;
        s.b1_full = f[0].full;
        s.b2_und  = f[1].und;
        s.b1_und  = f[0].und;
        s.b2_emp  = f[1].emp;
        s.b1_emp  = f[0].emp;
        s.d_ovr   = f[2].ovr;
        s.d_und   = f[2].und;
        s.d_emp   = f[2].emp;
        s.d_full  = f[2].full;
        return s;
    endfunction

endpackage

// File: rtl/isdn_chbuf_decode.sv
module isdn_chbuf_decode
    import isdn_chbuf_pkg::*;
#(
    parameter int NCH = N_CHAN
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              stat_rd,
    output logic [NCH-1:0]    ch_rd,
    output logic [NCH-1:0]    ch_wr
);

    assign stat_rd = rd && (addr == SEL_STAT);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(k + 1);
        assign ch_rd[k] = rd && (addr == CH_ADDR);
        assign ch_wr[k] = wr && (addr == CH_ADDR);
    end

endmodule

// File: rtl/isdn_chbuf_tx_lane.sv
module isdn_chbuf_tx_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sf,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         err_clr,
    output logic [W-1:0] line_out,
    output logic         empty,
    output logic         underrun
);

    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            line_out <= '0;
            empty    <= 1'b1;
            underrun <= 1'b0;
        end else begin
            if (sf)
                line_out <= hold_q;         // repeats stale data when empty
            if (wr_en)
                hold_q <= wr_data;
            if (wr_en)
                empty <= 1'b0;              // fresh data pending wins
            else if (sf)
                empty <= 1'b1;
            if (sf && empty)
                underrun <= 1'b1;           // set beats clear
            else if (err_clr)
                underrun <= 1'b0;
        end
    end

endmodule

// File: rtl/isdn_chbuf_rx_lane.sv
module isdn_chbuf_rx_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sf,
    input  logic [W-1:0] line_in,
    input  logic         rd_en,
    input  logic         err_clr,
    output logic [W-1:0] data,
    output logic         full,
    output logic         overrun
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data    <= '0;
            full    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (sf)
                data <= line_in;            // overwrite even when full
            if (sf)
                full <= 1'b1;
            else if (rd_en)
                full <= 1'b0;
            if (sf && full && !rd_en)
                overrun <= 1'b1;
            else if (err_clr)
                overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/isdn_chbuf.sv
module isdn_chbuf
    import isdn_chbuf_pkg::*;
#(
    parameter int B_W = B_WIDTH,
    parameter int D_W = D_WIDTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [B_W-1:0]    cpu_wdata,
    output logic [B_W-1:0]    cpu_rdata,
    input  logic              sf_tick,
    input  logic [B_W-1:0]    rx_b1_line,
    input  logic [B_W-1:0]    rx_b2_line,
    input  logic [D_W-1:0]    rx_d_line,
    output logic [B_W-1:0]    tx_b1_line,
    output logic [B_W-1:0]    tx_b2_line,
    output logic [D_W-1:0]    tx_d_line
);

    localparam int PAD_STAT = B_W - STAT_W;
    localparam int PAD_D    = B_W - D_W;

    logic               stat_rd;
    logic [N_CHAN-1:0]  ch_rd;
    logic [N_CHAN-1:0]  ch_wr;
    chan_flags_t        flags [N_CHAN];
    stat_t              stat_s;
    logic [STAT_W-1:0]  stat_w;

    logic [B_W-1:0]     b_rx_in   [N_BCH];
    logic [B_W-1:0]     b_rx_data [N_BCH];
    logic [B_W-1:0]     b_tx_out  [N_BCH];
    logic [D_W-1:0]     d_rx_data;

    isdn_chbuf_decode #(.NCH(N_CHAN)) u_dec (
        .addr    (cpu_addr),
        .rd      (cpu_rd),
        .wr      (cpu_wr),
        .stat_rd (stat_rd),
        .ch_rd   (ch_rd),
        .ch_wr   (ch_wr)
    );

    assign b_rx_in[0] = rx_b1_line;
    assign b_rx_in[1] = rx_b2_line;

    for (genvar i = 0; i < N_BCH; i++) begin : g_bch
        isdn_chbuf_tx_lane #(.W(B_W)) u_tx (
            .clk      (clk),
            .rst      (rst),
            .sf       (sf_tick),
            .wr_en    (ch_wr[i]),
            .wr_data  (cpu_wdata),
            .err_clr  (stat_rd),
            .line_out (b_tx_out[i]),
            .empty    (flags[i].emp),
            .underrun (flags[i].und)
        );
        isdn_chbuf_rx_lane #(.W(B_W)) u_rx (
            .clk     (clk),
            .rst     (rst),
            .sf      (sf_tick),
            .line_in (b_rx_in[i]),
            .rd_en   (ch_rd[i]),
            .err_clr (stat_rd),
            .data    (b_rx_data[i]),
            .full    (flags[i].full),
            .overrun (flags[i].ovr)
        );
    end

    isdn_chbuf_tx_lane #(.W(D_W)) u_d_tx (
        .clk      (clk),
        .rst      (rst),
        .sf       (sf_tick),
        .wr_en    (ch_wr[2]),
        .wr_data  (cpu_wdata[D_W-1:0]),
        .err_clr  (stat_rd),
        .line_out (tx_d_line),
        .empty    (flags[2].emp),
        .underrun (flags[2].und)
    );

    isdn_chbuf_rx_lane #(.W(D_W)) u_d_rx (
        .clk     (clk),
        .rst     (rst),
        .sf      (sf_tick),
        .line_in (rx_d_line),
        .rd_en   (ch_rd[2]),
        .err_clr (stat_rd),
        .data    (d_rx_data),
        .full    (flags[2].full),
        .overrun (flags[2].ovr)
    );

    assign tx_b1_line = b_tx_out[0];
    assign tx_b2_line = b_tx_out[1];

    assign stat_s = build_stat(flags);
    assign stat_w = stat_s;

    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            unique case (reg_sel_e'(cpu_addr))
                SEL_STAT: cpu_rdata = {{PAD_STAT{1'b0}}, stat_w};
                SEL_B1:   cpu_rdata = b_rx_data[0];
                SEL_B2:   cpu_rdata = b_rx_data[1];
                SEL_D:    cpu_rdata = {{PAD_D{1'b0}}, d_rx_data};
            endcase
        end
    end

endmodule

// File: rtl/isdn_chbuf_chk.sv
module isdn_chbuf_chk
    import isdn_chbuf_pkg::*;
#(
    parameter int B_W = B_WIDTH
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              sf_tick,
    input logic [B_W-1:0]    cpu_rdata,
    input logic [STAT_W-1:0] stat
);

    stat_t             s;
    logic              st_rd;
    logic              rd_b1;
    logic              rd_d;
    logic              wr_b1;
    logic              wr_b2;
    logic [STAT_W-1:0] err;

    assign s     = stat;
    assign st_rd = cpu_rd && (cpu_addr == SEL_STAT);
    assign rd_b1 = cpu_rd && (cpu_addr == SEL_B1);
    assign rd_d  = cpu_rd && (cpu_addr == SEL_D);
    assign wr_b1 = cpu_wr && (cpu_addr == SEL_B1);
    assign wr_b2 = cpu_wr && (cpu_addr == SEL_B2);
    assign err   = stat & ERR_MASK;

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        st_rd |-> (cpu_rdata[B_W-1:12] == '0));

    a_r3_tx_empty_set: assert property (@(posedge clk) disable iff (rst)
        (sf_tick && !wr_b1) |=> s.b1_emp);

    a_r4_underrun_set: assert property (@(posedge clk) disable iff (rst)
        (sf_tick && s.d_emp) |=> s.d_und);

    a_r5_write_clears_empty: assert property (@(posedge clk) disable iff (rst)
        wr_b2 |=> !s.b2_emp);

    a_r6_full_set: assert property (@(posedge clk) disable iff (rst)
        sf_tick |=> (s.b1_full && s.b2_full && s.d_full));

    a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (sf_tick && s.b1_full && !rd_b1) |=> s.b1_ovr);

    a_r8_read_clears_full: assert property (@(posedge clk) disable iff (rst)
        (rd_d && !sf_tick) |=> !s.d_full);

    a_r9_status_read_clears: assert property (@(posedge clk) disable iff (rst)
        (st_rd && !sf_tick) |=> (err == '0));

    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (st_rd && sf_tick && s.b2_emp) |=> s.b2_und);

    a_r11_errors_hold: assert property (@(posedge clk) disable iff (rst)
        !st_rd |=> ((err & $past(err)) == $past(err)));

endmodule

bind isdn_chbuf isdn_chbuf_chk #(.B_W(B_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .sf_tick   (sf_tick),
    .cpu_rdata (cpu_rdata),
    .stat      (stat_w)
);

// File: tb/isdn_chbuf_tb.sv
module isdn_chbuf_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SWEEP_N    = 6000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        sf_tick = 1'b0;
    logic [31:0] rx_b1_line = '0;
    logic [31:0] rx_b2_line = '0;
    logic [7:0]  rx_d_line = '0;
    logic [31:0] tx_b1_line;
    logic [31:0] tx_b2_line;
    logic [7:0]  tx_d_line;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Model state, index 0 = B1, 1 = B2, 2 = D.
    logic [31:0] m_tx [3];
    logic [31:0] m_sh [3];
    logic [31:0] m_rx [3];
    logic        m_emp [3];
    logic        m_und [3];
    logic        m_full [3];
    logic        m_ovr [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    isdn_chbuf u_dut (
        .clk        (clk),
        .rst        (rst),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .sf_tick    (sf_tick),
        .rx_b1_line (rx_b1_line),
        .rx_b2_line (rx_b2_line),
        .rx_d_line  (rx_d_line),
        .tx_b1_line (tx_b1_line),
        .tx_b2_line (tx_b2_line),
        .tx_d_line  (tx_d_line)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input int c);
        return (c == 2) ? 32'h0000_00FF : 32'hFFFF_FFFF;
    endfunction

    // R2 bit order: B2ovr B1ovr B2full B1full B2und B1und B2emp B1emp Dovr Dund Demp Dfull
    function automatic logic [31:0] exp_status();
        return {20'd0, m_ovr[1], m_ovr[0], m_full[1], m_full[0], m_und[1], m_und[0],
                m_emp[1], m_emp[0], m_ovr[2], m_und[2], m_emp[2], m_full[2]};
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_tx[c] = '0; m_sh[c] = '0; m_rx[c] = '0;
            m_emp[c] = 1'b1; m_und[c] = 1'b0; m_full[c] = 1'b0; m_ovr[c] = 1'b0;
        end
    endtask

    // One bus cycle; inputs are driven just after a rising edge.
    task automatic step(input string tag, input logic sf, input logic rd, input logic wr,
                        input logic [1:0] addr, input logic [31:0] wd,
                        input logic [31:0] i1, input logic [31:0] i2, input logic [7:0] id);
        logic [31:0] exp_rd;
        logic [31:0] rin [3];
        logic        st_rd;
        sf_tick = sf; cpu_rd = rd; cpu_wr = wr; cpu_addr = addr; cpu_wdata = wd;
        rx_b1_line = i1; rx_b2_line = i2; rx_d_line = id;
        rin[0] = i1; rin[1] = i2; rin[2] = {24'd0, id};
        #1;
        // R12: rdata is zero without a read strobe
        if (!rd)            exp_rd = '0;
        else if (addr == 0) exp_rd = exp_status();
        else                exp_rd = m_rx[addr-1];
        check(tag, cpu_rdata, exp_rd);
        st_rd = rd && (addr == 0);
        for (int c = 0; c < 3; c++) begin
            logic crd, cwr;
            crd = rd && (addr == 2'(c + 1));
            cwr = wr && (addr == 2'(c + 1));
            // transmit side
            if (sf) m_sh[c] = m_tx[c];
            if (sf && m_emp[c]) m_und[c] = 1'b1;
            else if (st_rd)     m_und[c] = 1'b0;
            if (cwr) begin
                m_tx[c]  = wd & mask_of(c);
                m_emp[c] = 1'b0;
            end else if (sf) m_emp[c] = 1'b1;
            // receive side
            if (sf && m_full[c] && !crd) m_ovr[c] = 1'b1;
            else if (st_rd)              m_ovr[c] = 1'b0;
            if (sf) begin
                m_rx[c]   = rin[c] & mask_of(c);
                m_full[c] = 1'b1;
            end else if (crd) m_full[c] = 1'b0;
        end
        @(posedge clk);
        #1;
        sf_tick = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        check({tag, " R3 b1 line"}, tx_b1_line, m_sh[0]);
        check({tag, " R3 b2 line"}, tx_b2_line, m_sh[1]);
        check({tag, " R3 d line"}, {24'd0, tx_d_line}, m_sh[2]);
    endtask

    task automatic rd_stat(input string tag);
        step(tag, 1'b0, 1'b1, 1'b0, 2'd0, '0, '0, '0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset state
        check("R1 status after reset", cpu_rdata, 32'd0);
        cpu_rd = 1'b1; cpu_addr = 2'd0; #1;
        check("R1 status value", cpu_rdata, 32'h0000_0032);
        cpu_rd = 1'b0;
        @(posedge clk); #1;
        step("R1 B1 data zero", 1'b0, 1'b1, 1'b0, 2'd1, '0, '0, '0, '0);
        step("R12 no strobe", 1'b0, 1'b0, 1'b0, 2'd2, '0, '0, '0, '0);

        // R5, R13: writes clear empty; D keeps low byte only
        step("R5 write B1", 1'b0, 1'b0, 1'b1, 2'd1, 32'hA1B2_C3D4, '0, '0, '0);
        step("R5 write B2", 1'b0, 1'b0, 1'b1, 2'd2, 32'h1357_9BDF, '0, '0, '0);
        step("R13 write D", 1'b0, 1'b0, 1'b1, 2'd3, 32'hFFFF_FF5A, '0, '0, '0);
        rd_stat("R5 empties cleared");

        // R3, R6: superframe moves data both ways
        step("R6 superframe", 1'b1, 1'b0, 1'b0, 2'd0, '0, 32'hDEAD_BEEF, 32'h0BAD_F00D, 8'hC3);
        rd_stat("R6 full set R3 empty set");
        step("R8 read B1", 1'b0, 1'b1, 1'b0, 2'd1, '0, '0, '0, '0);
        step("R13 read D", 1'b0, 1'b1, 1'b0, 2'd3, '0, '0, '0, '0);
        rd_stat("R8 full cleared");

        // R4, R7: unserviced superframe, errors raised, old tx repeats
        step("R4 R7 superframe", 1'b1, 1'b0, 1'b0, 2'd0, '0, 32'h1111_2222, 32'h3333_4444, 8'h55);
        // R7: read in the same cycle as the strobe takes the data
        step("R7 read with strobe", 1'b1, 1'b1, 1'b0, 2'd1, '0, 32'h6666_7777, 32'h8888_9999, 8'hAA);
        // R10: status read racing a setting strobe
        step("R10 read with strobe", 1'b1, 1'b1, 1'b0, 2'd0, '0, 32'h0, 32'h1, 8'h2);
        rd_stat("R10 flags kept");
        rd_stat("R9 errors cleared");
        step("R11 idle", 1'b0, 1'b0, 1'b0, 2'd0, '0, '0, '0, '0);
        rd_stat("R11 unchanged");

        // R8: read racing the strobe keeps full set
        step("R8 read with strobe", 1'b1, 1'b1, 1'b0, 2'd2, '0, 32'h1, 32'h2, 8'h3);
        rd_stat("R8 full kept");
        // R5: write racing the strobe
        step("R5 write with strobe", 1'b1, 1'b0, 1'b1, 2'd2, 32'hCAFE_0001, 32'h4, 32'h5, 8'h6);
        rd_stat("R5 empty clear after race");

        // Sweep: all ops mixed with strobes (R9, R6, R11, R12)
        for (int n = 0; n < SWEEP_N; n++) begin
            logic [31:0] r;
            logic [1:0]  a;
            r = $urandom;
            a = r[1:0];
            step((a == 0) ? "R9 sweep" : "R6 sweep", r[2] & r[3], r[4], r[5] & r[6], a,
                 $urandom, $urandom, $urandom, r[15:8]);
        end

        finish_run();
    end

endmodule